// File: doc/BRIEF.md
# Two-Level Glitch-Free Clock Selector

This block produces the processor clock and the peripheral clock from three free-running sources. The sources are a fast on-chip oscillator, a fast external clock and a slow sub clock. The first selection stage forms a main clock from one of the two fast sources. The second stage forms the processor clock from either that main clock or the slow sub clock. The peripheral clock is always the same signal as the processor clock.

Software controls the selection through one 8-bit control/status register, which is clocked by the processor clock. Two bits request a source, one for each stage. Two read-only bits report which source is really driving each stage at the moment. A request does not act at once. The stage keeps running on its old source, waits until that source's enable has drained through its synchronizer, and only then lets the new source's enable rise. The status bit therefore trails the request bit until the handover is complete.

A stage accepts a new request only when its previous handover has settled. A request written while a switch is still in progress is applied after the current switch ends.

Top module: `clksel_top`

## Requirements
- R1: After an active-low asynchronous reset, the register reads 0x00 and both clock outputs run from the fast internal oscillator.
- R2: A write stores bit 6 (processor source request: 0 = main, 1 = sub) and bit 4 (main source request: 0 = internal, 1 = external). Bits 7 and 5 cannot be written, and bits 3..0 always read 0.
- R3: Bit 5 reads 1 only while the external fast clock is actually driving the main clock. It still shows the old source immediately after the request is written.
- R4: Bit 7 reads 1 only while the sub clock is actually driving the processor clock. It still shows the old source immediately after the request is written.
- R5: No high or low phase of the processor clock is shorter than the shortest half-period of the sources taking part in a switch.
- R6: A handover completes within Tcpu + 3*Told + 3*Tnew after the write edge. Tcpu is the processor clock period at the write, Told is the period of the source being left and Tnew is the period of the source being taken.
- R7: The peripheral clock has the same level and period as the processor clock at all times.
- R8: When requests are written back to back while a switch is in progress, each stage finishes its current handover and then settles on the last value written.
- R9: Changing the main source while the processor clock runs from the sub clock updates bit 5. It leaves bit 7 and the processor clock period unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_hi_int | input | 1 | Fast on-chip oscillator |
| clk_hi_ext | input | 1 | Fast external clock |
| clk_lo_sub | input | 1 | Slow sub clock |
| wr_en | input | 1 | Register write strobe, sampled on the rising processor clock edge |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value (requests and live status) |
| clk_cpu | output | 1 | Selected processor clock |
| clk_periph | output | 1 | Peripheral clock, identical to clk_cpu |

## Verification
The sources run at 8 ns, 12 ns and 60 ns, so that each handover direction has a distinct ratio of old to new period. Directed switches cover every direction of both stages: slow to fast and fast to slow in the first stage, and main to sub and back in the second. Each switch is timed against its bound, and the resulting output period shows which source really took over. A switch of the first stage while the processor runs from the sub clock shows whether the two stages are independent. Writes spaced closer than a handover, in a directed case and in a seeded random sequence, show whether an interrupted switch ends on the last request without a short phase. A phase monitor covers all of these runs.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
   localparam int CSR_W         = 8;
   localparam int POS_CPU_STAT  = 7;
   localparam int POS_CPU_REQ   = 6;
   localparam int POS_MAIN_STAT = 5;
   localparam int POS_MAIN_REQ  = 4;
   localparam int SYNC_DEPTH    = 2;
endpackage

// File: rtl/clksel_ensync.sv
module clksel_ensync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b0
) (
   input  logic rst_n,
   input  logic clk,
   input  logic want,
   output logic busy,
   output logic en
);
   localparam int TOP = STAGES - 1;

   if (STAGES < 2) begin : g_depth_bad
      $error("clksel_ensync: STAGES must be at least 2");
   end

   logic [TOP:0] chain;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[TOP-1:0], want};
   end

   assign en   = chain[TOP];
   assign busy = |chain;
endmodule

// File: rtl/clksel_gfmux.sv
module clksel_gfmux #(
   parameter int STAGES    = 2,
   parameter bit RESET_SRC = 1'b0
) (
   input  logic rst_n,
   input  logic clk_ctl,
   input  logic req_b,
   input  logic clk_a,
   input  logic clk_b,
   output logic clk_o,
   output logic on_b
);
   localparam int TOP = STAGES - 1;

   logic sel_b;
   logic busy_a, busy_b, en_a, en_b;
   logic [TOP:0] seen_a, seen_b;
   logic settled;

   clksel_ensync #(.STAGES(STAGES), .RESET_VAL(!RESET_SRC)) u_side_a (
      .rst_n(rst_n), .clk(clk_a), .want(!sel_b && !busy_b),
      .busy(busy_a), .en(en_a));

   clksel_ensync #(.STAGES(STAGES), .RESET_VAL(RESET_SRC)) u_side_b (
      .rst_n(rst_n), .clk(clk_b), .want(sel_b && !busy_a),
      .busy(busy_b), .en(en_b));

   // live enables brought into the control domain
   always_ff @(posedge clk_ctl or negedge rst_n) begin
      if (!rst_n) begin
         seen_a <= {STAGES{!RESET_SRC}};
         seen_b <= {STAGES{RESET_SRC}};
      end else begin
         seen_a <= {seen_a[TOP-1:0], en_a};
         seen_b <= {seen_b[TOP-1:0], en_b};
      end
   end

   assign settled = (seen_b[TOP] == sel_b) && (seen_a[TOP] == !sel_b);

   // the applied select moves only once the previous handover is done
   always_ff @(posedge clk_ctl or negedge rst_n) begin
      if (!rst_n)       sel_b <= RESET_SRC;
      else if (settled) sel_b <= req_b;
   end

   assign clk_o = (clk_a & en_a) | (clk_b & en_b);
   assign on_b  = en_b;

   // R5
   excl_a_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
      !(en_a && en_b));
   // R5
   excl_b_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      !(en_a && en_b));
   // R6
   handoff_b_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      $rose(en_b) |-> !busy_a);
   // R6
   handoff_a_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
      $rose(en_a) |-> !busy_b);
endmodule

// File: rtl/clksel_top.sv
module clksel_top
   import clksel_pkg::*;
#(
   parameter int REG_W      = CSR_W,
   parameter int SYNC_STG   = SYNC_DEPTH,
   parameter int B_CPU_STAT = POS_CPU_STAT,
   parameter int B_CPU_REQ  = POS_CPU_REQ,
   parameter int B_MN_STAT  = POS_MAIN_STAT,
   parameter int B_MN_REQ   = POS_MAIN_REQ
) (
   input  logic             rst_n,
   input  logic             clk_hi_int,
   input  logic             clk_hi_ext,
   input  logic             clk_lo_sub,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             clk_cpu,
   output logic             clk_periph
);
   localparam int MAX_POS = REG_W - 1;

   if (B_CPU_STAT > MAX_POS || B_CPU_REQ > MAX_POS ||
       B_MN_STAT > MAX_POS || B_MN_REQ > MAX_POS) begin : g_pos_bad
      $error("clksel_top: field position outside register");
   end
   if (B_CPU_STAT == B_CPU_REQ || B_MN_STAT == B_MN_REQ ||
       B_CPU_REQ == B_MN_REQ || B_CPU_STAT == B_MN_STAT ||
       B_CPU_STAT == B_MN_REQ || B_CPU_REQ == B_MN_STAT) begin : g_pos_dup
      $error("clksel_top: field positions overlap");
   end

   logic req_cpu, req_main;
   logic clk_main, clk_cpu_i;
   logic main_on_ext, cpu_on_sub;

   always_ff @(posedge clk_cpu_i or negedge rst_n) begin
      if (!rst_n) begin
         req_cpu  <= 1'b0;
         req_main <= 1'b0;
      end else if (wr_en) begin
         req_cpu  <= wr_data[B_CPU_REQ];
         req_main <= wr_data[B_MN_REQ];
      end
   end

   clksel_gfmux #(.STAGES(SYNC_STG), .RESET_SRC(1'b0)) u_main_sel (
      .rst_n(rst_n), .clk_ctl(clk_cpu_i), .req_b(req_main),
      .clk_a(clk_hi_int), .clk_b(clk_hi_ext),
      .clk_o(clk_main), .on_b(main_on_ext));

   clksel_gfmux #(.STAGES(SYNC_STG), .RESET_SRC(1'b0)) u_cpu_sel (
      .rst_n(rst_n), .clk_ctl(clk_cpu_i), .req_b(req_cpu),
      .clk_a(clk_main), .clk_b(clk_lo_sub),
      .clk_o(clk_cpu_i), .on_b(cpu_on_sub));

   always_comb begin
      rd_data             = '0;
      rd_data[B_CPU_STAT] = cpu_on_sub;
      rd_data[B_CPU_REQ]  = req_cpu;
      rd_data[B_MN_STAT]  = main_on_ext;
      rd_data[B_MN_REQ]   = req_main;
   end

   assign clk_cpu    = clk_cpu_i;
   assign clk_periph = clk_cpu_i;

   // R2
   wr_cpu_req_chk: assert property (@(posedge clk_cpu_i) disable iff (!rst_n)
      wr_en |=> (req_cpu == $past(wr_data[B_CPU_REQ])));
   // R2
   wr_main_req_chk: assert property (@(posedge clk_cpu_i) disable iff (!rst_n)
      wr_en |=> (req_main == $past(wr_data[B_MN_REQ])));
   // R2
   req_hold_chk: assert property (@(posedge clk_cpu_i) disable iff (!rst_n)
      !wr_en |=> ($stable(req_cpu) && $stable(req_main)));
endmodule

// File: tb/sim_clksel_top.sv
`timescale 1ns/1ps
module sim_clksel_top;
   localparam real CLK_PERIOD = 8.0;
   localparam real T_EXT      = 12.0;
   localparam real T_SUB      = 60.0;
   localparam real MIN_PHASE  = CLK_PERIOD / 2.0;

   logic rst_n = 1'b0;
   logic c_int = 1'b0, c_ext = 1'b0, c_sub = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic clk_cpu, clk_periph;

   int checks = 0;
   int errors = 0;
   int runts  = 0;
   bit mon_on = 1'b0;
   bit mon_primed = 1'b0;
   bit done = 1'b0;
   real last_edge = 0.0;
   real t_wr = 0.0;

   clksel_top u0 (
      .rst_n(rst_n), .clk_hi_int(c_int), .clk_hi_ext(c_ext), .clk_lo_sub(c_sub),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .clk_cpu(clk_cpu), .clk_periph(clk_periph));

   always #(CLK_PERIOD / 2.0) c_int = ~c_int;
   initial begin #1.3; forever #(T_EXT / 2.0) c_ext = ~c_ext; end
   initial begin #2.7; forever #(T_SUB / 2.0) c_sub = ~c_sub; end

   // R5 phase monitor
   always @(clk_cpu) begin
      if (mon_on) begin
         if (mon_primed && ($realtime - last_edge) < MIN_PHASE - 0.001) runts++;
         mon_primed = 1'b1;
         last_edge = $realtime;
      end
   end

   function automatic real exp_period(input bit css, input bit mcm);
      if (css) return T_SUB;
      return mcm ? T_EXT : CLK_PERIOD;
   endfunction

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic chk(input string req, input string what, input bit ok,
                      input real act, input real exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, exp);
      end
   endtask

   task automatic write_reg(input logic [7:0] d);
      @(negedge clk_cpu);
      wr_en = 1'b1;
      wr_data = d;
      @(posedge clk_cpu);
      t_wr = $realtime;
      @(negedge clk_cpu);
      wr_en = 1'b0;
   endtask

   task automatic measure(input string req, input real exp);
      real t0, p;
      @(posedge clk_cpu);
      t0 = $realtime;
      @(posedge clk_cpu);
      p = $realtime - t0;
      chk(req, "clk_cpu period", (p > exp - 0.01) && (p < exp + 0.01), p, exp);
      #1;
      chk("R7", "clk_periph level", clk_periph === clk_cpu,
          real'(clk_periph), real'(clk_cpu));
   endtask

   task automatic timed_switch(input string req, input int pos, input bit want,
                               input real bound);
      real el;
      chk(req, "status trails request", rd_data[pos] !== want,
          real'(rd_data[pos]), real'(!want));
      for (int i = 0; i < 30000 && rd_data[pos] !== want; i++) #0.1;
      el = $realtime - t_wr;
      chk(req, "status reaches request", rd_data[pos] === want,
          real'(rd_data[pos]), real'(want));
      chk("R6", "handover latency", el <= bound, el, bound);
   endtask

   initial begin
      #1_000_000;
      chk("WD", "watchdog expired", 1'b0, $realtime, 0.0);
      report();
   end

   initial begin
      bit css, mcm;
      void'($urandom(32'd20240611));
      #50;
      chk("R1", "reset value", rd_data === 8'h00, real'(rd_data), 0.0);
      #3 rst_n = 1'b1;
      #20 mon_on = 1'b1;
      measure("R1", CLK_PERIOD);

      // R2 read-only and unused bits ignore writes
      write_reg(8'hAF);
      chk("R2", "read-only bits", rd_data === 8'h00, real'(rd_data), 0.0);
      #200;
      chk("R2", "no switch", rd_data === 8'h00, real'(rd_data), 0.0);
      measure("R2", CLK_PERIOD);

      // R3 main: internal -> external
      write_reg(8'h10);
      timed_switch("R3", 5, 1'b1, CLK_PERIOD + 3.0 * CLK_PERIOD + 3.0 * T_EXT);
      #100;
      chk("R3", "register", rd_data === 8'h30, real'(rd_data), real'(8'h30));
      measure("R3", T_EXT);

      // R4 cpu: main -> sub
      write_reg(8'h50);
      timed_switch("R4", 7, 1'b1, T_EXT + 3.0 * T_EXT + 3.0 * T_SUB);
      #200;
      chk("R4", "register", rd_data === 8'hF0, real'(rd_data), real'(8'hF0));
      measure("R4", T_SUB);

      // R9 main changes while cpu stays on sub
      write_reg(8'h40);
      timed_switch("R9", 5, 1'b0, T_SUB + 3.0 * T_EXT + 3.0 * CLK_PERIOD);
      #200;
      chk("R9", "cpu status kept", rd_data === 8'hC0, real'(rd_data), real'(8'hC0));
      measure("R9", T_SUB);

      // R4 cpu: sub -> main
      write_reg(8'h00);
      timed_switch("R4", 7, 1'b0, T_SUB + 3.0 * T_SUB + 3.0 * CLK_PERIOD);
      #100;
      measure("R4", CLK_PERIOD);

      // R8 back-to-back requests
      write_reg(8'h40);
      write_reg(8'h00);
      #1500;
      chk("R8", "cpu returns", rd_data === 8'h00, real'(rd_data), 0.0);
      measure("R8", CLK_PERIOD);
      write_reg(8'h10);
      write_reg(8'h00);
      write_reg(8'h10);
      #1500;
      chk("R8", "main ends on last", rd_data === 8'h30, real'(rd_data), real'(8'h30));
      measure("R8", T_EXT);

      // R8 random sequence, some writes spaced closer than a handover
      css = 1'b0; mcm = 1'b1;
      for (int k = 0; k < 14; k++) begin
         css = $urandom % 2;
         mcm = $urandom % 2;
         write_reg({1'b0, css, 1'b0, mcm, 4'h0});
         if (($urandom % 2) == 1) begin
            #1500;
            chk("R8", "random settle", rd_data === {css, css, mcm, mcm, 4'h0},
                real'(rd_data), real'({css, css, mcm, mcm, 4'h0}));
            measure("R8", exp_period(css, mcm));
         end else begin
            #($urandom % 40);
         end
      end
      #1500;
      chk("R8", "random final", rd_data === {css, css, mcm, mcm, 4'h0},
          real'(rd_data), real'({css, css, mcm, mcm, 4'h0}));
      measure("R8", exp_period(css, mcm));

      chk("R5", "short clk_cpu phases", runts == 0, real'(runts), 0.0);
      report();
   end
endmodule